// File: doc/BRIEF.md
# Multiplexed-Address Dynamic Memory Core

This block is a clock-synchronous, cycle-accurate model of a 16384-location, one-bit-wide dynamic memory. It is driven by active-low strobes. A 7-bit address bus carries two things in turn: the row number, taken when the row strobe goes low, and then the column number, taken when the column strobe goes low. The storage is a 128 by 128 bit matrix.

Opening a row copies all 128 bits of that row into a row buffer, which stands in for the sense amplifiers. Reads and writes then act on that buffer. Raising the row strobe copies the whole buffer back into the matrix, and that write-back is what refreshes the row. The block supports plain reads and writes, several column cycles inside one open row, a read followed by a write within one column cycle, and refresh cycles that use the row strobe alone.

A counter for each row measures the cycles since that row was last written back. A sticky flag reports that some row went longer than the refresh limit. A second sticky flag reports a column strobe issued with no row open. The pins are strobe-driven control, not a stream, so there is no valid/ready handshake and no back-pressure. `dout_valid` only marks when `dout` carries data. Every pin is sampled on the rising clock edge, and strobe edges are found by comparing each pin with its value at the previous edge.

Top module: `dram_core`

## Requirements
- R1: At the clock edge where `ras_n` is first sampled low, `addr` is latched as the row. From the next cycle on, `row_age` shows the cycles elapsed since that row was last written back. Reset sets every row's age to 0 and clears both flags and `dout_valid`.
- R2: Column address bits [5:0] choose one of 64 column pairs. Bit 6 picks the member of that pair, so bit index = 2*addr[5:0] + addr[6]. Every one of the 128 column addresses therefore names a different bit.
- R3: Suppose `cas_n` is sampled falling while a row is open and `we_n` is high. From the next cycle, `dout` holds the addressed bit and `dout_valid` is 1. It stays valid until the edge at which `cas_n` is sampled high.
- R4: If `we_n` is low when `cas_n` falls (early write), `din` replaces the addressed bit and `dout_valid` stays 0.
- R5: At the edge where `ras_n` is sampled rising, all 128 bits of the row buffer are written back. Data written in one row opening is read back in later openings.
- R6: While `ras_n` stays low, repeated `cas_n` cycles with new column addresses each read or write a different bit of the same open row.
- R7: After a read, `we_n` falling while `cas_n` is still low writes `din` to the column latched by that read (read-modify-write). `dout_valid` stays 1 until `cas_n` rises.
- R8: A cycle that uses `ras_n` alone never drives `dout_valid`. It preserves the row's data and resets that row's age to 0.
- R9: Each row's age increases by one per cycle and saturates at REFRESH_LIMIT+1. `refresh_err` rises once any age exceeds REFRESH_LIMIT and stays set until reset.
- R10: A `cas_n` fall sampled while `ras_n` is high is ignored: no data moves and no bit changes. It sets `proto_err`, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all pins sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 7 | Multiplexed row/column address |
| ras_n | input | 1 | Active-low row strobe |
| cas_n | input | 1 | Active-low column strobe |
| we_n | input | 1 | Active-low write enable |
| din | input | 1 | Write data bit |
| dout | output | 1 | Read data bit, meaningful when dout_valid is 1 |
| dout_valid | output | 1 | Read data present (models the high-impedance state when 0) |
| row_age | output | AGE_W | Refresh age of the latched row |
| refresh_err | output | 1 | Sticky: some row exceeded the refresh limit |
| proto_err | output | 1 | Sticky: column strobe seen with no row strobe |

## Verification
The following relations are checked on every cycle:
- `dout_valid` is never set unless the column strobe was low at the previous edge.
- `dout_valid` only rises after a read-enabled column fall.
- `proto_err` only rises after a column fall with the row strobe high.
- `refresh_err` never clears.
- `row_age` never passes its saturation value.

Some behaviour is only shown by the bench's scenarios, because it depends on storage across row openings:
- data persistence
- the distinctness of the 128 column addresses
- page-mode sequences
- read-modify-write results
- the preservation of data through refresh-only cycles and ignored strobes
- the exact age seen after a refresh

// File: rtl/dram_pkg.sv
package dram_pkg;

  typedef struct packed {
    logic fall;
    logic rise;
  } strobe_edge_t;

  function automatic strobe_edge_t edges_of(input logic prev_n, input logic now_n);
    strobe_edge_t e;
    e.fall = prev_n & ~now_n;
    e.rise = ~prev_n & now_n;
    return e;
  endfunction

endpackage

// File: rtl/dram_col_select.sv
module dram_col_select #(
  parameter int ADDR_W = 7,
  parameter int COLS   = 1 << ADDR_W
) (
  input  logic [ADDR_W-1:0] col_addr,
  input  logic [COLS-1:0]   row_bits,
  output logic [COLS-1:0]   sel_mask,
  output logic              sel_bit
);
  localparam int PAIRS = COLS / 2;

  // 1-of-64 pair decode, then 1-of-2 choice on the top address bit
  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    logic hit;
    assign hit             = (col_addr[ADDR_W-2:0] == (ADDR_W-1)'(p));
    assign sel_mask[2*p]   = hit & ~col_addr[ADDR_W-1];
    assign sel_mask[2*p+1] = hit &  col_addr[ADDR_W-1];
  end

  assign sel_bit = |(sel_mask & row_bits);
endmodule

// File: rtl/dram_refresh_tracker.sv
module dram_refresh_tracker #(
  parameter int ROWS  = 128,
  parameter int RW    = 7,
  parameter int LIMIT = 4000,
  parameter int AGE_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restore,
  input  logic [RW-1:0]    restore_row,
  input  logic [RW-1:0]    view_row,
  output logic [AGE_W-1:0] view_age,
  output logic             stale
);
  localparam logic [AGE_W-1:0] LIM = AGE_W'(LIMIT);
  localparam logic [AGE_W-1:0] SAT = AGE_W'(LIMIT + 1);

  logic [AGE_W-1:0] age [ROWS];
  logic [ROWS-1:0]  over;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    always_ff @(posedge clk) begin
      if (!rst_n)
        age[r] <= '0;
      else if (restore && restore_row == RW'(r))
        age[r] <= '0;
      else if (age[r] != SAT)
        age[r] <= age[r] + 1'b1;
    end
    assign over[r] = age[r] > LIM;
  end

  assign view_age = age[view_row];

  always_ff @(posedge clk) begin
    if (!rst_n)     stale <= 1'b0;
    else if (|over) stale <= 1'b1;
  end
endmodule

// File: rtl/dram_core.sv
module dram_core
  import dram_pkg::*;
#(
  parameter int ADDR_W        = 7,
  parameter int REFRESH_LIMIT = 4000,
  parameter int AGE_W         = $clog2(REFRESH_LIMIT + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic              din,
  output logic              dout,
  output logic              dout_valid,
  output logic [AGE_W-1:0]  row_age,
  output logic              refresh_err,
  output logic              proto_err
);
  localparam int ROWS = 1 << ADDR_W;
  localparam int COLS = 1 << ADDR_W;

  logic [COLS-1:0]   cells [ROWS];
  logic [COLS-1:0]   row_buf;
  logic [ADDR_W-1:0] row_q, col_q;
  logic              ras_q, cas_q, we_q, row_open, col_open;

  strobe_edge_t ras_e, cas_e;
  assign ras_e = edges_of(ras_q, ras_n);
  assign cas_e = edges_of(cas_q, cas_n);

  logic col_go, col_bad, late_wr;
  assign col_go  = cas_e.fall & ~ras_n & row_open;
  assign col_bad = cas_e.fall & ras_n;
  assign late_wr = we_q & ~we_n & ~cas_n & ~cas_q & col_open & row_open;

  logic [ADDR_W-1:0] col_sel;
  logic [COLS-1:0]   mask;
  logic              rd_bit;
  assign col_sel = col_go ? addr : col_q;

  dram_col_select #(.ADDR_W(ADDR_W), .COLS(COLS)) u_col (
    .col_addr (col_sel),
    .row_bits (row_buf),
    .sel_mask (mask),
    .sel_bit  (rd_bit)
  );

  dram_refresh_tracker #(
    .ROWS(ROWS), .RW(ADDR_W), .LIMIT(REFRESH_LIMIT), .AGE_W(AGE_W)
  ) u_ref (
    .clk         (clk),
    .rst_n       (rst_n),
    .restore     (ras_e.rise & row_open),
    .restore_row (row_q),
    .view_row    (row_q),
    .view_age    (row_age),
    .stale       (refresh_err)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ras_q <= 1'b1;
      cas_q <= 1'b1;
      we_q  <= 1'b1;
    end else begin
      ras_q <= ras_n;
      cas_q <= cas_n;
      we_q  <= we_n;
    end
  end

  // row open / restore
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_open <= 1'b0;
      row_q    <= '0;
    end else if (ras_e.fall) begin
      row_open <= 1'b1;
      row_q    <= addr;
    end else if (ras_e.rise) begin
      row_open <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (ras_e.rise && row_open)
      cells[row_q] <= row_buf;
  end

  always_ff @(posedge clk) begin
    if (ras_e.fall)
      row_buf <= cells[addr];
    else if ((col_go && !we_n) || late_wr)
      row_buf <= (row_buf & ~mask) | (din ? mask : '0);
  end

  // column cycle and data out
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col_q      <= '0;
      col_open   <= 1'b0;
      dout       <= 1'b0;
      dout_valid <= 1'b0;
    end else if (col_go) begin
      col_q      <= addr;
      col_open   <= 1'b1;
      dout_valid <= we_n;
      if (we_n) dout <= rd_bit;
    end else if (cas_e.rise || ras_e.rise) begin
      col_open   <= 1'b0;
      dout_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       proto_err <= 1'b0;
    else if (col_bad) proto_err <= 1'b1;
  end
endmodule

// File: rtl/dram_core_chk.sv
module dram_core_chk #(
  parameter int LIMIT = 4000,
  parameter int AGE_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ras_n,
  input logic             cas_n,
  input logic             we_n,
  input logic             dout_valid,
  input logic [AGE_W-1:0] row_age,
  input logic             refresh_err,
  input logic             proto_err
);
  assert_valid_needs_cas_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dout_valid |-> !$past(cas_n));

  assert_valid_only_on_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dout_valid) |-> $past(we_n));

  assert_proto_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(proto_err) |-> ($past(ras_n) && !$past(cas_n)));

  assert_refresh_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_err |=> refresh_err);

  assert_proto_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err);

  assert_age_saturates_R9: assert property (@(posedge clk) disable iff (!rst_n)
    row_age <= AGE_W'(LIMIT + 1));
endmodule

bind dram_core dram_core_chk #(.LIMIT(REFRESH_LIMIT), .AGE_W(AGE_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ras_n       (ras_n),
  .cas_n       (cas_n),
  .we_n        (we_n),
  .dout_valid  (dout_valid),
  .row_age     (row_age),
  .refresh_err (refresh_err),
  .proto_err   (proto_err)
);

// File: tb/sim_dram_core.sv
module sim_dram_core;
  localparam int CLK_PERIOD = 10;
  localparam int LIMIT      = 4000;
  localparam int AW         = $clog2(LIMIT + 2);

  logic clk = 1'b0;
  logic rst_n, ras_n, cas_n, we_n, din;
  logic [6:0] addr;
  logic dout, dout_valid, refresh_err, proto_err;
  logic [AW-1:0] row_age;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_core #(.ADDR_W(7), .REFRESH_LIMIT(LIMIT)) u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .din(din), .dout(dout), .dout_valid(dout_valid),
    .row_age(row_age), .refresh_err(refresh_err), .proto_err(proto_err)
  );

  // {row, col, write, din, expected}
  localparam int NV = 14;
  localparam logic [16:0] VEC [NV] = '{
    {7'd5,   7'd0,   1'b1, 1'b1, 1'b0},
    {7'd5,   7'd64,  1'b1, 1'b0, 1'b0},
    {7'd5,   7'd127, 1'b1, 1'b1, 1'b0},
    {7'd5,   7'd63,  1'b1, 1'b0, 1'b0},
    {7'd127, 7'd1,   1'b1, 1'b1, 1'b0},
    {7'd0,   7'd0,   1'b1, 1'b1, 1'b0},
    {7'd5,   7'd0,   1'b0, 1'b0, 1'b1},
    {7'd5,   7'd64,  1'b0, 1'b0, 1'b0},
    {7'd5,   7'd127, 1'b0, 1'b0, 1'b1},
    {7'd5,   7'd63,  1'b0, 1'b0, 1'b0},
    {7'd127, 7'd1,   1'b0, 1'b0, 1'b1},
    {7'd0,   7'd0,   1'b0, 1'b0, 1'b1},
    {7'd5,   7'd0,   1'b1, 1'b0, 1'b0},
    {7'd5,   7'd0,   1'b0, 1'b0, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic open_row(input logic [6:0] r);
    addr = r; tick(); ras_n = 1'b0; tick();
  endtask

  task automatic close_row();
    ras_n = 1'b1; tick();
  endtask

  // one column cycle in an open row; returns valid/data sampled after the fall
  task automatic col_cycle(input logic [6:0] c, input bit wr, input logic d,
                           output logic v, output logic q);
    addr = c; tick();
    cas_n = 1'b0; we_n = ~wr; din = d; tick();
    v = dout_valid; q = dout;
    cas_n = 1'b1; we_n = 1'b1; tick();
  endtask

  task automatic read_bit(input logic [6:0] r, input logic [6:0] c, output logic v, output logic q);
    open_row(r); col_cycle(c, 1'b0, 1'b0, v, q); close_row();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic v, q;
    rst_n = 1'b0; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; din = 1'b0; addr = '0;
    repeat (3) tick();
    // R1 reset state
    chk(dout_valid == 0, "R1 reset dout_valid", dout_valid, 0);
    chk(proto_err == 0, "R1 reset proto_err", proto_err, 0);
    chk(refresh_err == 0, "R1 reset refresh_err", refresh_err, 0);
    chk(row_age == 0, "R1 reset row_age", int'(row_age), 0);
    rst_n = 1'b1; tick();

    // vector table: R2 distinct columns, R3 reads, R4 early writes, R5 persistence
    for (int i = 0; i < NV; i++) begin
      open_row(VEC[i][16:10]);
      col_cycle(VEC[i][9:3], VEC[i][2], VEC[i][1], v, q);
      close_row();
      if (VEC[i][2])
        chk(v == 0, "R4 early write keeps dout invalid", v, 0);
      else begin
        chk(v == 1, "R3 read valid", v, 1);
        chk(q == VEC[i][0], "R2/R5 read data", q, VEC[i][0]);
      end
    end

    // R3 valid holds while cas low, drops after cas rises
    open_row(7'd5); addr = 7'd127; tick(); cas_n = 1'b0; tick(); tick();
    chk(dout_valid == 1 && dout == 1, "R3 valid held", dout_valid, 1);
    cas_n = 1'b1; tick();
    chk(dout_valid == 0, "R3 valid cleared on cas rise", dout_valid, 0);
    close_row();

    // R6 page mode
    open_row(7'd9);
    col_cycle(7'd10, 1'b1, 1'b1, v, q);
    col_cycle(7'd11, 1'b1, 1'b0, v, q);
    col_cycle(7'd74, 1'b1, 1'b1, v, q);
    col_cycle(7'd10, 1'b0, 1'b0, v, q); chk(v && q == 1, "R6 page read col10", q, 1);
    col_cycle(7'd11, 1'b0, 1'b0, v, q); chk(v && q == 0, "R6 page read col11", q, 0);
    col_cycle(7'd74, 1'b0, 1'b0, v, q); chk(v && q == 1, "R6 page read col74", q, 1);
    close_row();
    read_bit(7'd9, 7'd74, v, q); chk(q == 1, "R6 page data restored", q, 1);

    // R7 read-modify-write on row 9 col 11 (holds 0)
    open_row(7'd9); addr = 7'd11; tick();
    cas_n = 1'b0; tick();
    chk(dout_valid == 1 && dout == 0, "R7 rmw read phase", dout, 0);
    we_n = 1'b0; din = 1'b1; tick();
    chk(dout_valid == 1, "R7 valid held during late write", dout_valid, 1);
    cas_n = 1'b1; we_n = 1'b1; tick(); close_row();
    read_bit(7'd9, 7'd11, v, q); chk(q == 1, "R7 rmw value stored", q, 1);

    // R10 column strobe with row strobe high
    addr = 7'd127; tick(); cas_n = 1'b0; we_n = 1'b0; din = 1'b0; tick();
    chk(proto_err == 1, "R10 proto_err set", proto_err, 1);
    chk(dout_valid == 0, "R10 no data out", dout_valid, 0);
    cas_n = 1'b1; we_n = 1'b1; tick();
    read_bit(7'd5, 7'd127, v, q); chk(q == 1, "R10 memory unchanged", q, 1);
    chk(proto_err == 1, "R10 proto_err sticky", proto_err, 1);

    // R8 refresh every row with the row strobe alone
    v = 1'b0;
    for (int r = 0; r < 128; r++) begin
      addr = 7'(r); tick(); ras_n = 1'b0; tick(); v |= dout_valid; ras_n = 1'b1; tick();
      v |= dout_valid;
    end
    chk(v == 0, "R8 refresh drives no data", v, 0);
    chk(refresh_err == 0, "R9 no stale row yet", refresh_err, 0);
    // refresh row 5 then reopen immediately: age 1
    addr = 7'd5; tick(); ras_n = 1'b0; tick(); ras_n = 1'b1; tick();
    ras_n = 1'b0; tick();
    chk(row_age == 1, "R8 age cleared by refresh", int'(row_age), 1);
    ras_n = 1'b1; tick();
    read_bit(7'd5, 7'd127, v, q); chk(q == 1, "R8 data preserved", q, 1);

    // R9 let rows age past the limit
    repeat (LIMIT + 20) tick();
    chk(refresh_err == 1, "R9 refresh_err after limit", refresh_err, 1);
    open_row(7'd100);
    chk(row_age == AW'(LIMIT + 1), "R9 age saturates", int'(row_age), LIMIT + 1);
    close_row();
    tick();
    chk(refresh_err == 1, "R9 refresh_err sticky", refresh_err, 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule